// File: doc/BRIEF.md
# Dual-Processor Interrupt Router

This block collects 64 level-sensitive interrupt sources and steers each one, separately for each of two processors, onto one of five interrupt output lines. Every processor has a private bank of state: a 64-bit source mask, one line-select register per source, a mailbox word and a sticky external-bus request register. All of this sits behind a single 64-bit register read/write port. The processor that owns a bank is chosen by the top address bit.

A source reaches a line when three things hold: it is active, its mask bit is clear, and its line-select value names that line. Software finds the source through a status word. The status word lists the active, unmasked sources routed to line 0, and software services the highest set bit first. To move a source from one processor to the other, software masks it in one bank and unmasks it in the other.

The mailbox lets one processor interrupt the other. Its upper 16 bits together form one source. The external-bus register latches request pulses into both banks, and each bank is then cleared separately.

Top module: `imr_router`

## Requirements
- R1: After reset every mask bit in both banks reads 1, every line-select register reads 0, the mailbox and the external request register read 0, and all `irq_o` bits are 0.
- R2: A source that is active and has mask bit 1 drives no line. With mask bit 0 it drives the line its line-select register names. Mask is at byte offset 0x000.
- R3: The line-select register of source i is at byte offset 0x200 + 8*i and reads back its 3-bit value. Values 0 to 4 pick `irq_o` bit (cpu*5 + value). Values 5 to 7 pick no line.
- R4: Address bit 11 selects the bank (0 or 1). A write to one bank does not change the other bank's state or lines.
- R5: The status word at offset 0x008 equals the set of sources that are active, unmasked and routed to line 0.
- R6: A write to offset 0x018 sets mailbox bits where the data is 1. A write to offset 0x020 clears them where the data is 1. Both offsets read as 0. The mailbox reads at 0x010. Source 26 is active exactly when any of mailbox bits 63..48 is 1.
- R7: A pulse on `ext_req_i[i]` sets bit i of the request register (read at 0x028) in both banks. The bit stays set until a 1 is written to bit i at offset 0x030 in that bank, which clears only that bank's copy. A set request bit makes its source active.
- R8: When a request pulse and a clear write hit the same bit of a bank in the same cycle, the bit ends up set.
- R9: `rdata` and a one-cycle `rd_valid` pulse appear on the clock edge after `rd_en`. A write changes state, and with it `irq_o`, on the edge where `wr_en` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 64 | Level interrupt sources |
| ext_req_i | input | 64 | External-bus request pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address; bit 11 is the bank, bits 10..3 the register word |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, registered |
| rd_valid | output | 1 | Read data valid |
| irq_o | output | 10 | Interrupt lines; bank 0 uses bits 4..0, bank 1 uses bits 9..5 |

## Verification
Two updates can target the same request bit in the same cycle: a latched external pulse and a software clear of that bit. The bench sets one request bit ahead of time. It then drives a new pulse on a second bit in exactly the cycle where the clear write covers both bits. The design is judged by reading the register back: the bit that was only cleared must read 0, and the bit that was also pulsed must read 1. The bench also confirms that the other bank's copy is left alone.

// File: rtl/imr_pkg.sv
// Shared register word indices for the interrupt router.
// Assumes 8-byte registers, so a byte offset shifted right by 3 gives the word.
package imr_pkg;
    localparam int unsigned WORD_W   = 8;
    localparam logic [WORD_W-1:0] W_MASK  = 8'h00;
    localparam logic [WORD_W-1:0] W_STAT  = 8'h01;
    localparam logic [WORD_W-1:0] W_MBOX  = 8'h02;
    localparam logic [WORD_W-1:0] W_MSET  = 8'h03;
    localparam logic [WORD_W-1:0] W_MCLR  = 8'h04;
    localparam logic [WORD_W-1:0] W_PEND  = 8'h05;
    localparam logic [WORD_W-1:0] W_PCLR  = 8'h06;
    localparam logic [WORD_W-1:0] W_MAP   = 8'h40;
endpackage

// File: rtl/imr_line_route.sv
// Line router: ORs the active sources routed to each output line and
// produces the line-0 status vector. Purely combinational.
// Assumes select values at or above NLINE route nowhere.
module imr_line_route #(
    parameter int unsigned NSRC  = 64,
    parameter int unsigned NLINE = 5,
    parameter int unsigned MAPW  = 3
) (
    input  logic [NSRC-1:0]           active_i,
    input  logic [NSRC-1:0][MAPW-1:0] map_i,
    output logic [NLINE-1:0]          line_o,
    output logic [NSRC-1:0]           status_o
);
    logic [NLINE-1:0][NSRC-1:0] sel;

    for (genvar k = 0; k < NLINE; k++) begin : g_line
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            // Source i is routed to line k
            assign sel[k][i] = (map_i[i] == MAPW'(k));
        end
        // Line k rises when any routed source is active
        assign line_o[k] = |(active_i & sel[k]);
    end

    // Status covers line 0 only
    assign status_o = active_i & sel[0];
endmodule

// File: rtl/imr_cpu_bank.sv
// One processor's register bank: mask, per-source line select, mailbox
// and sticky external request register, plus the read mux for its words.
// Assumes NSRC equals DW; the write strobe arrives already qualified by bank.
module imr_cpu_bank
    import imr_pkg::*;
#(
    parameter int unsigned NSRC     = 64,
    parameter int unsigned DW       = 64,
    parameter int unsigned NLINE    = 5,
    parameter int unsigned MAPW     = 3,
    parameter int unsigned MBOX_SRC = 26,
    parameter int unsigned MBOX_LO  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [NSRC-1:0]   ext_req_i,
    input  logic              we_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [NLINE-1:0]  line_o,
    output logic [DW-1:0]     rd_word_o
);
    localparam int unsigned IDXW = $clog2(NSRC);

    logic [NSRC-1:0]           mask_q, mbox_q, pend_q;
    logic [NSRC-1:0][MAPW-1:0] map_q;
    logic [NSRC-1:0]           mset_v, mclr_v, pclr_v;
    logic [NSRC-1:0]           eff, active, status;
    logic                      is_map;
    logic [IDXW-1:0]           map_idx;

    assign is_map  = (word_i[WORD_W-1:IDXW] == W_MAP[WORD_W-1:IDXW]);
    assign map_idx = word_i[IDXW-1:0];

    // Decode the one-shot set and clear vectors of this cycle's write
    always_comb begin
        mset_v = (we_i && word_i == W_MSET) ? wdata_i : '0;
        mclr_v = (we_i && word_i == W_MCLR) ? wdata_i : '0;
        pclr_v = (we_i && word_i == W_PCLR) ? wdata_i : '0;
    end

    // Mask, mailbox and request state; set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            mbox_q <= '0;
            pend_q <= '0;
        end else begin
            if (we_i && word_i == W_MASK) mask_q <= wdata_i;
            mbox_q <= (mbox_q & ~mclr_v) | mset_v;
            pend_q <= (pend_q & ~pclr_v) | ext_req_i;
        end
    end

    // Per-source line select registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (we_i && is_map) begin
            map_q[map_idx] <= wdata_i[MAPW-1:0];
        end
    end

    // Effective sources: level input or latched request; mailbox overrides its slot
    always_comb begin
        eff           = src_i | pend_q;
        eff[MBOX_SRC] = |mbox_q[DW-1:MBOX_LO];
        active        = eff & ~mask_q;
    end

    imr_line_route #(.NSRC(NSRC), .NLINE(NLINE), .MAPW(MAPW)) u_route (
        .active_i (active),
        .map_i    (map_q),
        .line_o   (line_o),
        .status_o (status)
    );

    // Read mux for this bank's words
    always_comb begin
        rd_word_o = '0;
        if (is_map) begin
            rd_word_o[MAPW-1:0] = map_q[map_idx];
        end else begin
            case (word_i)
                W_MASK:  rd_word_o = mask_q;
                W_STAT:  rd_word_o = status;
                W_MBOX:  rd_word_o = mbox_q;
                W_PEND:  rd_word_o = pend_q;
                default: rd_word_o = '0;
            endcase
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(pend_q) & ~$past(pclr_v)) & ~pend_q) == '0)); // R7
    AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(ext_req_i) & ~pend_q) == '0)); // R8
    AST_STATUS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (status & mask_q) == '0); // R5
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> (line_o == '0)); // R2
endmodule

// File: rtl/imr_router.sv
// Top of the dual-processor interrupt router: one register bank per
// processor selected by the upper address bit, and a registered read port.
// Assumes a single request per cycle on the register port.
module imr_router
    import imr_pkg::*;
#(
    parameter int unsigned NSRC     = 64,
    parameter int unsigned DW       = 64,
    parameter int unsigned NCPU     = 2,
    parameter int unsigned NLINE    = 5,
    parameter int unsigned MAPW     = 3,
    parameter int unsigned MBOX_SRC = 26,
    parameter int unsigned MBOX_LO  = 48,
    parameter int unsigned OFFW     = 11,
    parameter int unsigned CPUW     = (NCPU > 1) ? $clog2(NCPU) : 1,
    parameter int unsigned AW       = OFFW + CPUW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       src_i,
    input  logic [NSRC-1:0]       ext_req_i,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    output logic [DW-1:0]         rdata,
    output logic                  rd_valid,
    output logic [NCPU*NLINE-1:0] irq_o
);
    logic [CPUW-1:0]       cpu_sel;
    logic [WORD_W-1:0]     word;
    logic [NCPU-1:0][DW-1:0] bank_rd;

    assign cpu_sel = addr[AW-1:OFFW];
    assign word    = addr[OFFW-1:3];

    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        imr_cpu_bank #(
            .NSRC(NSRC), .DW(DW), .NLINE(NLINE), .MAPW(MAPW),
            .MBOX_SRC(MBOX_SRC), .MBOX_LO(MBOX_LO)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i),
            .ext_req_i (ext_req_i),
            .we_i      (wr_en && (cpu_sel == CPUW'(c))),
            .word_i    (word),
            .wdata_i   (wdata),
            .line_o    (irq_o[c*NLINE +: NLINE]),
            .rd_word_o (bank_rd[c])
        );
    end

    // Registered read data and valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= bank_rd[cpu_sel];
        end
    end

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en)); // R9
endmodule

// File: tb/imr_router_bench.sv
module imr_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [63:0] ext_req_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rd_valid;
    logic [9:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    imr_router u_imr_router (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .ext_req_i(ext_req_i),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rd_valid(rd_valid), .irq_o(irq_o)
    );

    function automatic logic [11:0] ad(input int cpu, input int word);
        return {cpu[0], word[7:0], 3'b000};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one write at a falling edge; takes effect on the next rising edge
    task automatic wr(input int cpu, input int word, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ad(cpu, word); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read one word; data is sampled at the falling edge after the capture
    task automatic rd(input int cpu, input int word, output logic [63:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = ad(cpu, word);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 rd_valid", {63'd0, rd_valid}, 64'd1);
        d = rdata;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk("R1 irq_o", {54'd0, irq_o}, 64'd0);
        rd(0, 8'h00, d); chk("R1 mask0", d, '1);
        rd(1, 8'h00, d); chk("R1 mask1", d, '1);
        rd(0, 8'h02, d); chk("R1 mbox", d, 0);
        rd(1, 8'h05, d); chk("R1 pend", d, 0);
        rd(0, 8'h45, d); chk("R1 map5", d, 0);
        @(negedge clk);
        chk("R9 rd_valid drops", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic t_mask_route();
        logic [63:0] d;
        src_i = 64'h8;
        @(negedge clk);
        chk("R2 masked", {54'd0, irq_o}, 0);
        wr(0, 8'h00, ~64'h8);
        chk("R2 unmasked line0", {54'd0, irq_o}, 64'h1);
        chk("R4 bank1 quiet", {59'd0, irq_o[9:5]}, 0);
        rd(0, 8'h01, d); chk("R5 status", d, 64'h8);
        rd(1, 8'h01, d); chk("R4 status1", d, 0);
        wr(0, 8'h43, 64'd2);
        chk("R3 line2", {54'd0, irq_o}, 64'h4);
        rd(0, 8'h01, d); chk("R5 status off line0", d, 0);
        rd(0, 8'h43, d); chk("R3 readback", d, 64'd2);
        wr(0, 8'h43, 64'd6);
        chk("R3 sel6 none", {54'd0, irq_o}, 0);
        wr(0, 8'h43, 64'd4);
        chk("R3 line4", {54'd0, irq_o}, 64'h10);
        wr(1, 8'h00, ~64'h8);
        chk("R4 bank1 line0", {54'd0, irq_o}, 64'h30);
        wr(0, 8'h00, '1);
        chk("R2 remasked", {54'd0, irq_o}, 64'h20);
        wr(1, 8'h00, '1);
        src_i = '0;
        @(negedge clk);
        chk("R2 all quiet", {54'd0, irq_o}, 0);
    endtask

    task automatic t_mailbox();
        logic [63:0] d;
        wr(1, 8'h00, ~(64'd1 << 26));
        chk("R6 empty mbox", {54'd0, irq_o}, 0);
        wr(1, 8'h03, 64'd1 << 50);
        chk("R6 mbox high raises", {54'd0, irq_o}, 64'h20);
        rd(1, 8'h02, d); chk("R6 mbox value", d, 64'd1 << 50);
        rd(1, 8'h03, d); chk("R6 set reads 0", d, 0);
        rd(0, 8'h02, d); chk("R4 mbox0 untouched", d, 0);
        wr(1, 8'h03, 64'd1 << 10);
        wr(1, 8'h04, 64'd1 << 50);
        chk("R6 low bits no source", {54'd0, irq_o}, 0);
        rd(1, 8'h02, d); chk("R6 after clear", d, 64'd1 << 10);
        wr(1, 8'h04, '1);
        rd(1, 8'h02, d); chk("R6 clear all", d, 0);
        wr(1, 8'h00, '1);
    endtask

    task automatic t_pending();
        logic [63:0] d;
        @(negedge clk);
        ext_req_i = 64'h80;
        @(negedge clk);
        ext_req_i = '0;
        rd(0, 8'h05, d); chk("R7 pend0", d, 64'h80);
        rd(1, 8'h05, d); chk("R7 pend1", d, 64'h80);
        wr(0, 8'h00, ~64'h80);
        chk("R7 pend drives line", {54'd0, irq_o}, 64'h1);
        wr(0, 8'h06, 64'h80);
        chk("R7 cleared line", {54'd0, irq_o}, 0);
        rd(0, 8'h05, d); chk("R7 pend0 cleared", d, 0);
        rd(1, 8'h05, d); chk("R7 pend1 kept", d, 64'h80);
        wr(1, 8'h06, 64'h80);
        rd(1, 8'h05, d); chk("R7 pend1 cleared", d, 0);
        wr(0, 8'h00, '1);
    endtask

    task automatic t_collide();
        logic [63:0] d;
        @(negedge clk);
        ext_req_i = 64'h100;
        @(negedge clk);
        ext_req_i = 64'h200;
        wr_en = 1'b1; addr = ad(0, 8'h06); wdata = 64'h300;
        @(negedge clk);
        ext_req_i = '0; wr_en = 1'b0;
        rd(0, 8'h05, d); chk("R8 set wins over clear", d, 64'h200);
        rd(1, 8'h05, d); chk("R8 other bank", d, 64'h300);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_route();
        t_mailbox();
        t_pending();
        t_collide();
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 5000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule